// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects sixteen interrupt request lines, numbered 0 to 15, and passes one vector at a time to a processor core. A lower line number has higher priority. Line 0 is the reset request. When it fires, the core is held in a halted state and the controller returns to a clean state. Lines 0 to 3 form a fixed group that no mask can block. Each of lines 4 to 15 is taken only when both its own enable bit and a global enable bit are set.

A rising edge on a line sets a pending flag. Software can also set or clear pending flags through two mask inputs. The controller looks at the pending flags only on every second clock edge. When it recognizes the highest-priority eligible flag, it waits a fixed latency and then presents the vector. The vector stays on the outputs until the core acknowledges it. The acknowledge clears that flag and starts a fixed servicing hold-off, during which nothing new is recognized.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output goes to zero after that edge: no vector, no pending flags, all enables clear, global enable clear, halt low.
- R2: A 0-to-1 change on a line, sampled at edge k, sets its pending bit after edge k. A line that stays high sets its bit only once, so it is not dispatched again after its acknowledge.
- R3: Among the eligible pending lines, the one with the lowest number is recognized first.
- R4: Lines 0 to 3 are eligible whenever they are pending, whatever the enables hold. Bits 0 to 3 of the enable register ignore writes and always read back as 0, so writing all ones reads back as 16'hFFF0.
- R5: A pending line numbered 4 or higher is recognized only while its enable bit and the global enable are both 1. Until then it stays pending and no vector appears.
- R6: Edges are counted from 0, starting at the first edge after reset is released. A recognition happens only on an even-numbered edge, so two recognitions are always at least two cycles apart.
- R7: `vec_valid` rises 11 edges after the recognition edge. `vec_id` then holds the recognized line number, and both stay unchanged until an acknowledge.
- R8: At the edge where `vec_valid` rises, the global enable is cleared.
- R9: `ack` sampled high while `vec_valid` is high clears the pending bit of `vec_id` and drops `vec_valid` at that same edge. `ack` while `vec_valid` is low has no effect.
- R10: If an acknowledge is taken at edge a, no recognition happens before edge a+7. The next recognition is therefore on the first even edge at or after a+7.
- R11: A bit set in `flag_set` makes that pending bit 1 after the edge. A bit set in `flag_clr` makes it 0. When both masks hold the same bit, set wins.
- R12: A rising edge on line 0 does the following at the sampling edge: it clears every other pending bit, all enables and the global enable, cancels any dispatch in progress, and raises `cpu_halt`. Vector 0 then follows the normal recognition and latency rules, and `cpu_halt` drops at the acknowledge of vector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 16 | Interrupt request lines, edge sensitive |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 16 | New enable register value |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable (wins over set) |
| flag_set | input | 16 | Per-line pending set mask |
| flag_clr | input | 16 | Per-line pending clear mask |
| ack | input | 1 | Core acknowledge of the presented vector |
| vec_valid | output | 1 | A vector is being presented |
| vec_id | output | 4 | Number of the presented line |
| cpu_halt | output | 1 | Core hold from a line-0 event until its vector is acknowledged |
| pend_o | output | 16 | Pending flags |
| en_o | output | 16 | Enable register |
| gie_o | output | 1 | Global enable |

## Verification
Each stimulus is driven in the cycle before edge k, and the bench records k. It then places the expected vector at negative-edge count r+12. Here r is the first even edge that is not before k+1 and not before seven edges after the last acknowledge. A scoreboard queue holds the expected line number and due cycle, and a monitor compares them on every rising `vec_valid`. An unexpected vector, such as one that a line-0 event should have cancelled, is an error. Flag, enable and halt effects are read one edge after the driving edge. Masked lines are watched for tens of cycles to confirm that no vector appears.

// File: rtl/irq_prio_pkg.sv
// Shared defaults and types for the prioritized interrupt controller.
// Assumes one clock domain; every consumer takes its sizes as parameters.
package irq_prio_pkg;
    localparam int DEF_LINES    = 16;  // request lines
    localparam int DEF_NMI      = 4;   // lowest lines that no mask can block
    localparam int DEF_LATENCY  = 11;  // edges from recognition to vector
    localparam int DEF_OVERHEAD = 7;   // hold-off edges after an acknowledge

    // Dispatch engine state
    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_WAIT = 2'd1,
        DS_SHOW = 2'd2
    } disp_state_e;
endpackage

// File: rtl/irq_flag_bank.sv
// Pending flag bank: detects rising edges on the request lines and keeps
// one flag per line. Software masks, the acknowledge clear and the line-0
// wipe act on the flags. Line 0 is assumed to be the reset request.
module irq_flag_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] pend,
    output logic         wipe
);
    localparam logic [N-1:0] ONLY_ZERO = N'(1);

    logic [N-1:0] lines_q;
    logic [N-1:0] rise;

    assign rise = lines & ~lines_q;
    assign wipe = rise[0];

    // Previous line levels, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines;
    end

    // Flag update: a wipe keeps only line 0; otherwise clears apply first, then sets
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= '0;
        else if (wipe) pend <= ONLY_ZERO;
        else           pend <= (pend & ~sw_clr & ~ack_clr) | sw_set | rise;
    end

    // R11
    sw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && (sw_set != '0)) |=> ((pend & $past(sw_set)) == $past(sw_set)));
endmodule

// File: rtl/irq_mask_regs.sv
// Enable register, global enable and per-line eligibility. The lowest NMI
// lines are always eligible when pending. Enable bits of those lines are
// held at zero. The global enable drops on every dispatch.
module irq_mask_regs #(
    parameter int N   = 16,
    parameter int NMI = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    input  logic         gie_set,
    input  logic         gie_clr,
    input  logic         launch,
    input  logic [N-1:0] pend,
    output logic [N-1:0] en,
    output logic         gie,
    output logic [N-1:0] elig
);
    localparam logic [N-1:0] WR_MASK = {{(N-NMI){1'b1}}, {NMI{1'b0}}};

    // Enable register: writable only above the fixed group
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) en <= '0;
        else if (en_we)     en <= en_wdata & WR_MASK;
    end

    // Global enable: a dispatch or a clear wins over a set
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)       gie <= 1'b0;
        else if (launch || gie_clr) gie <= 1'b0;
        else if (gie_set)         gie <= 1'b1;
    end

    // Eligibility per line, fixed group versus masked group
    for (genvar i = 0; i < N; i++) begin : g_elig
        if (i < NMI) begin : g_fixed
            assign elig[i] = pend[i];
        end else begin : g_masked
            assign elig[i] = pend[i] & en[i] & gie;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: reports whether any line is eligible and which
// eligible line has the lowest number. Purely combinational.
module irq_prio_pick #(
    parameter int N    = 16,
    parameter int ID_W = 4
) (
    input  logic [N-1:0]    elig,
    output logic            found,
    output logic [ID_W-1:0] pick
);
    // Scan from the top down so that the lowest set index is kept last
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                pick  = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_dispatch.sv
// Dispatch engine: recognizes a candidate only on even edges when idle and
// past the service hold-off. It waits LATENCY edges, then presents the
// vector until it is acknowledged. A wipe cancels everything in flight.
module irq_dispatch
    import irq_prio_pkg::*;
#(
    parameter int ID_W     = 4,
    parameter int LATENCY  = 11,
    parameter int OVERHEAD = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wipe,
    input  logic            cand_valid,
    input  logic [ID_W-1:0] cand_id,
    input  logic            ack,
    output logic            vec_valid,
    output logic [ID_W-1:0] vec_id,
    output logic            launch,
    output logic            take
);
    localparam int LAT_W = $clog2(LATENCY + 1);
    localparam int GAP_W = $clog2(OVERHEAD + 1);

    disp_state_e      st;
    logic             phase;
    logic [LAT_W-1:0] lat_cnt;
    logic [GAP_W-1:0] gap_cnt;
    logic             rec;

    assign rec       = (st == DS_IDLE) && cand_valid && !phase && (gap_cnt == '0) && !wipe;
    assign launch    = (st == DS_WAIT) && (lat_cnt == '0) && !wipe;
    assign take      = (st == DS_SHOW) && ack && !wipe;
    assign vec_valid = (st == DS_SHOW);

    // Recognition cadence: slot open on every other edge after reset
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    // State, latency and hold-off counters
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            st      <= DS_IDLE;
            lat_cnt <= '0;
            gap_cnt <= '0;
            if (!rst_n) vec_id <= '0;
        end else begin
            case (st)
                DS_IDLE: begin
                    if (rec) begin
                        st      <= DS_WAIT;
                        lat_cnt <= LAT_W'(LATENCY - 1);
                        vec_id  <= cand_id;
                    end else if (gap_cnt != '0) begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end
                end
                DS_WAIT: begin
                    if (lat_cnt == '0) st <= DS_SHOW;
                    else               lat_cnt <= lat_cnt - 1'b1;
                end
                DS_SHOW: begin
                    if (ack) begin
                        st      <= DS_IDLE;
                        gap_cnt <= GAP_W'(OVERHEAD - 1);
                    end
                end
                default: st <= DS_IDLE;
            endcase
        end
    end

    // R6
    cadence_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec |=> !rec);

    // R7
    vector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !ack && !wipe) |=> (vec_valid && $stable(vec_id)));

    // R10
    holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !rec);

    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !vec_valid);
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the prioritized interrupt controller. It connects the flag bank,
// the mask registers, the priority picker and the dispatch engine, and it
// keeps the core halt that a line-0 event raises. All inputs are assumed
// synchronous to clk.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_LINES = DEF_LINES,
    parameter int NMI_LINES = DEF_NMI,
    parameter int LATENCY   = DEF_LATENCY,
    parameter int OVERHEAD  = DEF_OVERHEAD,
    localparam int ID_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 en_we,
    input  logic [NUM_LINES-1:0] en_wdata,
    input  logic                 gie_set,
    input  logic                 gie_clr,
    input  logic [NUM_LINES-1:0] flag_set,
    input  logic [NUM_LINES-1:0] flag_clr,
    input  logic                 ack,
    output logic                 vec_valid,
    output logic [ID_W-1:0]      vec_id,
    output logic                 cpu_halt,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] en_o,
    output logic                 gie_o
);
    localparam logic [NUM_LINES-1:0] ONLY_ZERO = NUM_LINES'(1);

    logic [NUM_LINES-1:0] pend, en, elig, ack_clr;
    logic                 gie, wipe, found, launch, take;
    logic [ID_W-1:0]      pick;

    assign ack_clr = take ? (ONLY_ZERO << vec_id) : '0;

    irq_flag_bank #(.N(NUM_LINES)) u_flags (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines), .sw_set(flag_set),
        .sw_clr(flag_clr), .ack_clr(ack_clr), .pend(pend), .wipe(wipe)
    );

    irq_mask_regs #(.N(NUM_LINES), .NMI(NMI_LINES)) u_mask (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .en_we(en_we), .en_wdata(en_wdata),
        .gie_set(gie_set), .gie_clr(gie_clr), .launch(launch), .pend(pend),
        .en(en), .gie(gie), .elig(elig)
    );

    irq_prio_pick #(.N(NUM_LINES), .ID_W(ID_W)) u_pick (
        .elig(elig), .found(found), .pick(pick)
    );

    irq_dispatch #(.ID_W(ID_W), .LATENCY(LATENCY), .OVERHEAD(OVERHEAD)) u_disp (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .cand_valid(found), .cand_id(pick),
        .ack(ack), .vec_valid(vec_valid), .vec_id(vec_id), .launch(launch), .take(take)
    );

    // Core halt: raised by a line-0 event, released when vector 0 is acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n)                        cpu_halt <= 1'b0;
        else if (wipe)                     cpu_halt <= 1'b1;
        else if (take && (vec_id == '0))   cpu_halt <= 1'b0;
    end

    assign pend_o = pend;
    assign en_o   = en;
    assign gie_o  = gie;

    // R12
    wipe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> ((pend == ONLY_ZERO) && (en == '0) && !gie && !vec_valid && cpu_halt));

    // R8
    gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> !gie);
endmodule

// File: tb/irq_prio_ctrl_test.sv
// Scoreboard bench: drivers queue the expected vector and its due cycle,
// and a monitor compares them on each rising vec_valid.
module irq_prio_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_lines, en_wdata, flag_set, flag_clr;
    logic        en_we, gie_set, gie_clr, ack;
    logic        vec_valid, cpu_halt, gie_o;
    logic [3:0]  vec_id;
    logic [15:0] pend_o, en_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .en_we(en_we),
        .en_wdata(en_wdata), .gie_set(gie_set), .gie_clr(gie_clr),
        .flag_set(flag_set), .flag_clr(flag_clr), .ack(ack),
        .vec_valid(vec_valid), .vec_id(vec_id), .cpu_halt(cpu_halt),
        .pend_o(pend_o), .en_o(en_o), .gie_o(gie_o)
    );

    typedef struct { int id; int due; } exp_t;
    exp_t q[$];
    int errors = 0, checks = 0, cyc = 0, gap_ok = 0, last_ack = 0;
    logic vv_q = 1'b0;

    // Edge counter from reset release
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp_v);
        end
    endtask

    // Due negedge count for a stimulus sampled at edge k
    function automatic int due_for(input int k, input int earliest);
        int r = k + 1;
        if (r < earliest) r = earliest;
        if ((r % 2) != 0) r++;
        return r + 12;
    endfunction

    task automatic push(input int id, input int due);
        exp_t e;
        e.id = id; e.due = due;
        q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Monitor: compare each new vector with the scoreboard head
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && vec_valid && !vv_q) begin
            if (q.size() == 0) begin
                chk(1'b0, "R12", "unexpected vector", int'(vec_id), -1);
            end else begin
                e = q.pop_front();
                chk(int'(vec_id) == e.id, "R3", "vector id", int'(vec_id), e.id);
                chk(cyc == e.due, "R7", "arrival cycle (R6 slot)", cyc, e.due);
            end
        end
        vv_q = vec_valid;
    end

    // Pulse lines high for one sampled edge; returns the sampling edge
    task automatic raise(input logic [15:0] m, output int k);
        irq_lines = irq_lines | m;
        k = cyc;
        tick(1);
        irq_lines = irq_lines & ~m;
    endtask

    // Wait for the vector, acknowledge it, verify the drop
    task automatic serve();
        int n = 0;
        while (!vec_valid && n < 80) begin tick(1); n++; end
        chk(vec_valid, "R7", "vector presented", int'(vec_valid), 1);
        ack = 1'b1;
        last_ack = cyc;
        tick(1);
        ack = 1'b0;
        gap_ok = last_ack + 7;
        chk(!vec_valid, "R9", "vec_valid after ack", int'(vec_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=0", 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int k;
        rst_n = 1'b0; irq_lines = '0; en_we = 0; en_wdata = '0; gie_set = 0;
        gie_clr = 0; flag_set = '0; flag_clr = '0; ack = 0;
        tick(3);
        // R1 reset state
        chk({vec_valid, cpu_halt, gie_o, pend_o, en_o} == '0, "R1", "reset outputs",
            int'({pend_o, en_o}), 0);
        rst_n = 1'b1;
        tick(4);

        // R4 fixed line taken with nothing enabled
        raise(16'h0004, k);
        push(2, due_for(k, gap_ok));
        chk(pend_o[2], "R2", "pending after edge", int'(pend_o), 16'h0004);
        serve();
        chk(pend_o == 16'h0000, "R9", "flag cleared by ack", int'(pend_o), 0);

        // R5 masked line waits for enable and global enable
        tick(20);
        raise(16'h0020, k);
        tick(30);
        chk(pend_o == 16'h0020 && !vec_valid, "R5", "masked line pending", int'(pend_o), 16'h0020);
        en_we = 1; en_wdata = 16'hFFFF; tick(1); en_we = 0;
        chk(en_o == 16'hFFF0, "R4", "enable readback", int'(en_o), 16'hFFF0);
        tick(20);
        chk(!vec_valid, "R5", "no vector without global enable", int'(vec_valid), 0);
        gie_set = 1; k = cyc; tick(1); gie_set = 0;
        chk(gie_o, "R5", "global enable set", int'(gie_o), 1);
        push(5, due_for(k, gap_ok));
        serve();
        chk(!gie_o, "R8", "global enable dropped on dispatch", int'(gie_o), 0);

        // R3 priority among several, masked ones wait for re-enable
        tick(20);
        gie_set = 1; tick(1); gie_set = 0;
        raise(16'h0288, k);
        push(3, due_for(k, gap_ok));
        serve();
        tick(20);
        chk(pend_o == 16'h0280, "R5", "masked lines left after dispatch", int'(pend_o), 16'h0280);
        gie_set = 1; k = cyc; tick(1); gie_set = 0;
        push(7, due_for(k, gap_ok));
        serve();
        tick(10);
        gie_set = 1; k = cyc; tick(1); gie_set = 0;
        push(9, due_for(k, gap_ok));
        serve();

        // R10 hold-off after ack; R2 line 1 stays high
        tick(20);
        irq_lines = 16'h0006; k = cyc; tick(1); irq_lines = 16'h0002;
        push(1, due_for(k, gap_ok));
        serve();
        push(2, due_for(last_ack, last_ack + 7));
        serve();
        tick(40);
        chk(pend_o[1] == 1'b0 && !vec_valid, "R2", "held line not re-taken", int'(pend_o), 0);
        irq_lines = '0;

        // R11 software set/clear, R9 stray ack ignored
        tick(20);
        en_we = 1; en_wdata = 16'h0000; tick(1); en_we = 0;
        flag_set = 16'h0040; tick(1); flag_set = '0;
        chk(pend_o == 16'h0040, "R11", "software set", int'(pend_o), 16'h0040);
        ack = 1; tick(1); ack = 0;
        chk(pend_o == 16'h0040 && !vec_valid, "R9", "stray ack ignored", int'(pend_o), 16'h0040);
        flag_set = 16'h0040; flag_clr = 16'h0040; tick(1); flag_set = '0; flag_clr = '0;
        chk(pend_o == 16'h0040, "R11", "set wins over clear", int'(pend_o), 16'h0040);
        flag_clr = 16'h0040; tick(1); flag_clr = '0;
        chk(pend_o == 16'h0000, "R11", "software clear", int'(pend_o), 0);
        flag_set = 16'h0008; k = cyc; tick(1); flag_set = '0;
        push(3, due_for(k, gap_ok));
        serve();

        // R12 line-0 event cancels an in-flight dispatch
        tick(20);
        en_we = 1; en_wdata = 16'h0010; tick(1); en_we = 0;
        gie_set = 1; flag_set = 16'h0100; tick(1); gie_set = 0; flag_set = '0;
        raise(16'h0004, k);
        tick(4);
        raise(16'h0001, k);
        push(0, due_for(k, gap_ok));
        chk(pend_o == 16'h0001 && en_o == 16'h0000 && !gie_o, "R12", "state wiped",
            int'(pend_o), 1);
        chk(cpu_halt, "R12", "halt raised", int'(cpu_halt), 1);
        tick(8);
        chk(cpu_halt, "R12", "halt held before ack", int'(cpu_halt), 1);
        serve();
        chk(!cpu_halt, "R12", "halt released by ack of vector 0", int'(cpu_halt), 0);

        tick(30);
        chk(q.size() == 0, "R7", "all expected vectors arrived", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule